// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns one configuration-space request into the address a host bridge drives for it. The request gives a bus number, a combined device/function byte, a byte register offset, an access size and, for writes, the data. Bus zero is the local bus. There the block builds a type-0 address that selects the target with a single set bit. For any other bus it builds a type-1 address that carries the encoded bus, device and function. The configuration address is then placed into a sparse window: it is shifted up, the access length is encoded in the low bits, and a configurable base is added.

A type-1 access needs the top two bits of a configuration extension register set to `01` while it runs. The block reads the current register value when it accepts the request. It writes the overridden value before it issues the address, and it writes the original value back once the bus reports completion. Write data is moved onto the byte lanes that match the offset. Read data is moved down from those lanes and cut to the requested size.

The controller has seven states:
- `ST_IDLE` waits for `req_valid`. From there it goes to `ST_REJECT` for an illegal request, to `ST_APPLY` for type-1 and to `ST_ISSUE` for type-0.
- `ST_REJECT` acknowledges with the error flag and returns to `ST_IDLE`.
- `ST_APPLY` writes the override and moves to `ST_ISSUE`.
- `ST_ISSUE` presents the address and acknowledges, then moves to `ST_WAIT`.
- `ST_WAIT` holds until `bus_done`. It then goes to `ST_RESTORE` for type-1 and to `ST_COMPLETE` for type-0.
- `ST_RESTORE` writes back the saved register value and moves to `ST_COMPLETE`.
- `ST_COMPLETE` reports the completion and returns to `ST_IDLE`.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 produces a type-0 cycle (`bus_type1`=0). Any nonzero bus number produces a type-1 cycle (`bus_type1`=1).
- R2: A type-0 request whose device number (`req_devfn[7:3]`) exceeds 20 is acknowledged with `req_err`=1. It produces no `bus_valid`, no extension register write and no completion.
- R3: A type-0 address has exactly one set bit among bits 31:11, at position 11 plus the device number. Its bits 10:8 hold the function (`req_devfn[2:0]`), bits 7:2 hold `req_offset[7:2]`, and bits 1:0 are `00`.
- R4: A type-1 address has bits 31:24 zero, the bus number in 23:16, the device in 15:11, the function in 10:8, `req_offset[7:2]` in 7:2, and `01` in bits 1:0.
- R5: `sparse_addr` equals `CFG_BASE` + (configuration address << 5) + (size − 1) × 8.
- R6: For a type-1 access, `ext_wdata` = {2'b01, original[29:0]} is written with `ext_wr`, where the original is the `ext_cur` value at acceptance. This write happens in the cycle before `bus_valid`.
- R7: For a type-1 access, the original value is written back after `bus_done` and before `cpl_valid`.
- R8: `bus_wdata` equals `req_wdata` shifted left by `req_offset[1:0]` × 8 bits, truncated to 32 bits.
- R9: `cpl_rdata` equals `bus_rdata` shifted right by offset[1:0] × 8, masked to 8, 16 or 32 bits for sizes 1, 2 and 4. A write completes with `cpl_rdata`=0.
- R10: `bus_valid` and `req_ack` are high together for exactly one cycle per accepted request. `req_err` is only ever high together with `req_ack`.
- R11: A size other than 1, 2 or 4 is rejected in the same way as R2.
- R12: A type-0 access never asserts `ext_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken in idle |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device [7:3], function [2:0] |
| req_offset | input | 8 | Byte register offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data, right-justified |
| req_ack | output | 1 | Request acknowledged (one cycle) |
| req_err | output | 1 | Device-not-found / bad size, with ack |
| cfg_addr | output | 32 | Configuration address |
| bus_type1 | output | 1 | Type-1 cycle flag |
| sparse_addr | output | SPARSE_W | Sparse-window bus address |
| bus_valid | output | 1 | Address valid (one cycle) |
| bus_write | output | 1 | Access direction |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_done | input | 1 | Bus transaction finished |
| bus_rdata | input | 32 | Raw read data, valid with bus_done |
| ext_cur | input | 32 | Current extension register value |
| ext_wr | output | 1 | Extension register write strobe |
| ext_wdata | output | 32 | Extension register write value |
| cpl_valid | output | 1 | Completion strobe |
| cpl_rdata | output | 32 | Extracted read data |

## Verification
Type-0 reads are driven with device numbers 0, 5 and 20, and one is driven with 21. These separate a correct one-hot select at both ends of the legal range from an off-by-one bound. Type-1 reads and writes use several buses and offsets. They show whether bus, device and function land in their own fields, whether the `01` tag is set, and whether the extension register is overridden and restored around the access. Sizes 1, 2 and 4 are combined with all four lane offsets, which exposes wrong shift amounts, wrong masks and a wrong length code in the sparse address. A size of 3 shows that illegal lengths are refused.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;
    localparam int OFF_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 32;
    localparam int LANE_W  = $clog2(DATA_W / 8);
    localparam int LEN_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_ISSUE,
        ST_WAIT,
        ST_RESTORE,
        ST_COMPLETE,
        ST_REJECT
    } cfg_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] cfg;
        logic              type1;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [LANE_W-1:0] lane;
        logic [SIZE_W-1:0] size;
    } cfg_req_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

    // (size - 1) * 8 for the legal sizes
    function automatic logic [LEN_W-1:0] size_len(input logic [SIZE_W-1:0] s);
        logic [LEN_W-1:0] r;
        unique case (s)
            3'd2:    r = 5'd8;
            3'd4:    r = 5'd24;
            default: r = 5'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cfg_addr_encode.sv
module cfg_addr_encode
    import cfg_addr_pkg::*;
#(
    parameter int               MAX_DEV      = 20,
    parameter int               SEL_BASE     = 11,
    parameter int               SPARSE_SHIFT = 5,
    parameter int               SPARSE_W     = 40,
    parameter logic [SPARSE_W-1:0] CFG_BASE  = 40'h3A_0000_0000
) (
    input  logic [BUS_W-1:0]    bus_num,
    input  logic [DEVFN_W-1:0]  devfn,
    input  logic [OFF_W-1:0]    offset,
    input  logic [SIZE_W-1:0]   size,
    output logic [ADDR_W-1:0]   cfg_addr,
    output logic                is_type1,
    output logic                bad,
    output logic [SPARSE_W-1:0] sparse
);
    localparam int DEV_W = DEVFN_W - 3;

    logic [DEV_W-1:0]  dev;
    logic [2:0]        fn;
    logic [ADDR_W-1:0] sel;
    logic [ADDR_W-1:0] t0_addr;
    logic [ADDR_W-1:0] t1_addr;
    logic [ADDR_W-1:0] reg_part;

    assign dev      = devfn[DEVFN_W-1:3];
    assign fn       = devfn[2:0];
    assign is_type1 = (bus_num != '0);
    assign reg_part = ADDR_W'({offset[OFF_W-1:2], 2'b00});

    // one-hot device select, one comparator per address bit
    for (genvar i = 0; i < ADDR_W; i++) begin : g_sel
        assign sel[i] = (i == SEL_BASE + int'(dev));
    end

    assign t0_addr = sel | (ADDR_W'(fn) << 8) | reg_part;
    assign t1_addr = (ADDR_W'(bus_num) << 16) | (ADDR_W'(devfn) << 8)
                   | reg_part | ADDR_W'(2'b01);

    always_comb begin
        cfg_addr = is_type1 ? t1_addr : t0_addr;
        bad      = !size_legal(size) || (!is_type1 && (int'(dev) > MAX_DEV));
        sparse   = CFG_BASE + (SPARSE_W'(cfg_addr) << SPARSE_SHIFT)
                 + SPARSE_W'(size_len(size));
    end
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
    import cfg_addr_pkg::*;
(
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [DATA_W-1:0] wdata_out,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic [SIZE_W-1:0] rd_size,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] rdata_out
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] rshift;
    logic [DATA_W-1:0] mask;

    assign wdata_out = wdata_in << {wr_lane, 3'b000};
    assign rshift    = rdata_in >> {rd_lane, 3'b000};

    // byte b survives when b is below the access size
    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        assign mask[b*8 +: 8] = {8{(b < int'(rd_size))}};
    end

    assign rdata_out = rshift & mask;
endmodule

// File: rtl/cfg_ext_override.sv
module cfg_ext_override
    import cfg_addr_pkg::*;
#(
    parameter int                    FORCE_BITS = 2,
    parameter logic [FORCE_BITS-1:0] FORCE_VAL  = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] ext_in,
    output logic [DATA_W-1:0] apply_val,
    output logic [DATA_W-1:0] restore_val
);
    logic [DATA_W-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            saved_q <= '0;
        else if (capture)
            saved_q <= ext_in;
    end

    assign apply_val   = {FORCE_VAL, saved_q[DATA_W-FORCE_BITS-1:0]};
    assign restore_val = saved_q;
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_addr_pkg::*;
#(
    parameter int                  MAX_DEV      = 20,
    parameter int                  SEL_BASE     = 11,
    parameter int                  SPARSE_SHIFT = 5,
    parameter int                  SPARSE_W     = 40,
    parameter logic [SPARSE_W-1:0] CFG_BASE     = 40'h3A_0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [7:0]          req_bus,
    input  logic [7:0]          req_devfn,
    input  logic [7:0]          req_offset,
    input  logic [2:0]          req_size,
    input  logic                req_write,
    input  logic [31:0]         req_wdata,
    output logic                req_ack,
    output logic                req_err,
    output logic [31:0]         cfg_addr,
    output logic                bus_type1,
    output logic [SPARSE_W-1:0] sparse_addr,
    output logic                bus_valid,
    output logic                bus_write,
    output logic [31:0]         bus_wdata,
    input  logic                bus_done,
    input  logic [31:0]         bus_rdata,
    input  logic [31:0]         ext_cur,
    output logic                ext_wr,
    output logic [31:0]         ext_wdata,
    output logic                cpl_valid,
    output logic [31:0]         cpl_rdata
);
    cfg_state_e state_q, state_d;
    cfg_req_t   req_q;

    logic [SPARSE_W-1:0] sparse_q;
    logic [DATA_W-1:0]   rd_q;

    logic [ADDR_W-1:0]   enc_addr;
    logic                enc_type1;
    logic                enc_bad;
    logic [SPARSE_W-1:0] enc_sparse;
    logic [DATA_W-1:0]   wdata_al;
    logic [DATA_W-1:0]   rdata_ex;
    logic [DATA_W-1:0]   ext_apply;
    logic [DATA_W-1:0]   ext_restore;
    logic                accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    cfg_addr_encode #(
        .MAX_DEV(MAX_DEV), .SEL_BASE(SEL_BASE), .SPARSE_SHIFT(SPARSE_SHIFT),
        .SPARSE_W(SPARSE_W), .CFG_BASE(CFG_BASE)
    ) u_encode (
        .bus_num (req_bus),
        .devfn   (req_devfn),
        .offset  (req_offset),
        .size    (req_size),
        .cfg_addr(enc_addr),
        .is_type1(enc_type1),
        .bad     (enc_bad),
        .sparse  (enc_sparse)
    );

    cfg_lane_align u_lane (
        .wr_lane  (req_offset[LANE_W-1:0]),
        .wdata_in (req_wdata),
        .wdata_out(wdata_al),
        .rd_lane  (req_q.lane),
        .rd_size  (req_q.size),
        .rdata_in (bus_rdata),
        .rdata_out(rdata_ex)
    );

    cfg_ext_override u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (accept),
        .ext_in     (ext_cur),
        .apply_val  (ext_apply),
        .restore_val(ext_restore)
    );

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            sparse_q <= '0;
            rd_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q.cfg   <= enc_addr;
                req_q.type1 <= enc_type1;
                req_q.write <= req_write;
                req_q.wdata <= wdata_al;
                req_q.lane  <= req_offset[LANE_W-1:0];
                req_q.size  <= req_size;
                sparse_q    <= enc_sparse;
            end
            if ((state_q == ST_WAIT) && bus_done)
                rd_q <= req_q.write ? '0 : rdata_ex;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (enc_bad)        state_d = ST_REJECT;
                    else if (enc_type1) state_d = ST_APPLY;
                    else                state_d = ST_ISSUE;
                end
            end
            ST_REJECT:   state_d = ST_IDLE;
            ST_APPLY:    state_d = ST_ISSUE;
            ST_ISSUE:    state_d = ST_WAIT;
            ST_WAIT: begin
                if (bus_done)
                    state_d = req_q.type1 ? ST_RESTORE : ST_COMPLETE;
            end
            ST_RESTORE:  state_d = ST_COMPLETE;
            ST_COMPLETE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ack   = 1'b0;
        req_err   = 1'b0;
        bus_valid = 1'b0;
        ext_wr    = 1'b0;
        ext_wdata = '0;
        cpl_valid = 1'b0;
        unique case (state_q)
            ST_REJECT: begin
                req_ack = 1'b1;
                req_err = 1'b1;
            end
            ST_APPLY: begin
                ext_wr    = 1'b1;
                ext_wdata = ext_apply;
            end
            ST_ISSUE: begin
                req_ack   = 1'b1;
                bus_valid = 1'b1;
            end
            ST_RESTORE: begin
                ext_wr    = 1'b1;
                ext_wdata = ext_restore;
            end
            ST_COMPLETE: cpl_valid = 1'b1;
            default: ;
        endcase
    end

    assign cfg_addr    = req_q.cfg;
    assign bus_type1   = req_q.type1;
    assign bus_write   = req_q.write;
    assign bus_wdata   = req_q.wdata;
    assign sparse_addr = sparse_q;
    assign cpl_rdata   = rd_q;
endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ack,
    input logic        req_err,
    input logic [31:0] cfg_addr,
    input logic        bus_type1,
    input logic        bus_valid,
    input logic        ext_wr,
    input logic [31:0] ext_wdata,
    input logic        cpl_valid
);
    logic [1:0] ext_top;
    assign ext_top = ext_wdata[31:30];

    // R10
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> req_ack ##1 !bus_valid);

    // R10
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ack && !bus_valid);

    // R2
    no_issue_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !bus_valid && !ext_wr);

    // R3
    type0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_type1 |-> ($countones(cfg_addr[31:11]) == 1) && (cfg_addr[1:0] == 2'b00));

    // R4
    type1_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_type1 |-> (cfg_addr[31:24] == 8'h00) && (cfg_addr[1:0] == 2'b01));

    // R6
    override_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_type1 |-> $past(ext_wr) && ($past(ext_top) == 2'b01));

    // R12
    type0_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_type1 |-> !$past(ext_wr));

    // R9
    cpl_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);
endmodule

bind cfg_addr_gen cfg_addr_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ack  (req_ack),
    .req_err  (req_err),
    .cfg_addr (cfg_addr),
    .bus_type1(bus_type1),
    .bus_valid(bus_valid),
    .ext_wr   (ext_wr),
    .ext_wdata(ext_wdata),
    .cpl_valid(cpl_valid)
);

// File: tb/test_cfg_addr_gen.sv
module test_cfg_addr_gen;
    localparam int SPARSE_W = 40;
    localparam logic [SPARSE_W-1:0] BASE = 40'h3A_0000_0000;
    localparam logic [31:0] EXT_INIT = 32'hFFFF_1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_bus = '0, req_devfn = '0, req_offset = '0;
    logic [2:0] req_size = 3'd4;
    logic req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic req_ack, req_err, bus_type1, bus_valid, bus_write, ext_wr, cpl_valid;
    logic [31:0] cfg_addr, bus_wdata, ext_wdata, cpl_rdata;
    logic [SPARSE_W-1:0] sparse_addr;
    logic bus_done = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] ext_q;
    int ext_wr_cnt;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_addr_gen i_cfg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_offset(req_offset), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_err(req_err), .cfg_addr(cfg_addr), .bus_type1(bus_type1),
        .sparse_addr(sparse_addr), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .ext_cur(ext_q), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
        .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata)
    );

    // extension register model
    always @(posedge clk) begin
        if (!rst_n) begin
            ext_q      <= EXT_INIT;
            ext_wr_cnt <= 0;
        end else if (ext_wr) begin
            ext_q      <= ext_wdata;
            ext_wr_cnt <= ext_wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cfg(input logic [7:0] bus, input logic [7:0] devfn, input logic [7:0] off,
                           input logic [2:0] size, input bit wr, input logic [31:0] wdata,
                           input logic [31:0] resp);
        int dev = int'(devfn[7:3]);
        bit exp_bad = !(size == 1 || size == 2 || size == 4) || (bus == 0 && dev > 20);
        bit exp_t1 = (bus != 0);
        logic [31:0] exp_cfg, exp_wd, exp_rd, mask, ext_at_ack, a_cfg, a_wd, a_rd;
        logic [SPARSE_W-1:0] exp_sp, a_sp;
        int acks = 0, wr0, cpls = 0;
        bit a_err = 0, a_t1 = 0, ack_prev = 0;
        logic [31:0] ext_start;
        if (exp_t1) exp_cfg = (32'(bus) << 16) | (32'(devfn) << 8) | 32'({off[7:2], 2'b01});
        else        exp_cfg = (32'h1 << (11 + dev)) | (32'(devfn[2:0]) << 8) | 32'({off[7:2], 2'b00});
        exp_sp = BASE + (SPARSE_W'(exp_cfg) << 5) + SPARSE_W'((int'(size) - 1) * 8);
        exp_wd = wdata << (off[1:0] * 8);
        mask = (size == 1) ? 32'hFF : (size == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        exp_rd = wr ? 32'h0 : ((resp >> (off[1:0] * 8)) & mask);
        @(negedge clk);
        ext_start = ext_q; wr0 = ext_wr_cnt;
        req_bus = bus; req_devfn = devfn; req_offset = off; req_size = size;
        req_write = wr; req_wdata = wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 12; c++) begin
            bus_done = ack_prev && !a_err;
            bus_rdata = resp;
            ack_prev = req_ack;
            if (req_ack) begin
                acks++; a_err = req_err; a_cfg = cfg_addr; a_t1 = bus_type1;
                a_sp = sparse_addr; a_wd = bus_wdata; ext_at_ack = ext_q;
            end
            if (cpl_valid) begin cpls++; a_rd = cpl_rdata; end
            @(negedge clk);
        end
        bus_done = 1'b0;
        check(acks == 1, "R10 ack count", 64'(acks), 64'd1);
        check(a_err == exp_bad, "R2/R11 err flag", 64'(a_err), 64'(exp_bad));
        if (exp_bad) begin
            check(cpls == 0 && ext_wr_cnt == wr0, "R2 reject side effects", 64'(cpls), 64'd0);
        end else begin
            check(a_t1 == exp_t1, "R1 cycle type", 64'(a_t1), 64'(exp_t1));
            check(a_cfg == exp_cfg, exp_t1 ? "R4 type1 addr" : "R3 type0 addr", 64'(a_cfg), 64'(exp_cfg));
            check(a_sp == exp_sp, "R5 sparse addr", 64'(a_sp), 64'(exp_sp));
            if (wr) check(a_wd == exp_wd, "R8 write lanes", 64'(a_wd), 64'(exp_wd));
            check(cpls == 1 && a_rd == exp_rd, "R9 read data", 64'(a_rd), 64'(exp_rd));
            if (exp_t1) begin
                check(ext_at_ack == {2'b01, ext_start[29:0]}, "R6 override", 64'(ext_at_ack),
                      64'({2'b01, ext_start[29:0]}));
                check(ext_q == ext_start && ext_wr_cnt == wr0 + 2, "R7 restore", 64'(ext_q), 64'(ext_start));
            end else begin
                check(ext_wr_cnt == wr0 && ext_q == ext_start, "R12 no ext write",
                      64'(ext_wr_cnt - wr0), 64'd0);
            end
        end
    endtask

    task automatic test_reset();
        check(!req_ack && !bus_valid && !ext_wr && !cpl_valid && !req_err, "R10 reset idle",
              64'({req_ack, bus_valid, ext_wr, cpl_valid}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_cfg(8'd0, {5'd0, 3'd0},  8'h00, 3'd4, 1'b0, 32'h0, 32'hDEAD_BEEF);
        run_cfg(8'd0, {5'd5, 3'd3},  8'h3D, 3'd1, 1'b0, 32'h0, 32'h1122_3344);
        run_cfg(8'd0, {5'd20, 3'd7}, 8'hFE, 3'd2, 1'b0, 32'h0, 32'hA1B2_C3D4);
        run_cfg(8'd0, {5'd21, 3'd0}, 8'h10, 3'd4, 1'b0, 32'h0, 32'h0);
        run_cfg(8'd0, {5'd2, 3'd0},  8'h10, 3'd3, 1'b0, 32'h0, 32'h0);
        run_cfg(8'd1, {5'd31, 3'd5}, 8'hFF, 3'd1, 1'b0, 32'h0, 32'h5566_7788);
        run_cfg(8'hA5, {5'd9, 3'd2}, 8'h42, 3'd2, 1'b1, 32'h0000_BEEF, 32'h0);
        run_cfg(8'd0, {5'd3, 3'd1},  8'h07, 3'd1, 1'b1, 32'h0000_00C3, 32'h0);
        run_cfg(8'hFF, {5'd0, 3'd0}, 8'h04, 3'd4, 1'b1, 32'hCAFE_F00D, 32'h0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule